// File: doc/BRIEF.md
# SDRAM Command and Power-Mode Sequencer

This block sits between a memory controller's scheduler and the command pins of an SDRAM or synchronous flash device. Each request names one abstract operation, along with a bank and an address. The block drives the matching clock-enable, chip-select, row-strobe, column-strobe and write-enable pattern, plus the bank and address lines, from registers. Every command is followed by at least one deselect cycle. When no request is pending, the block drives deselect. Pins that the device ignores for a given command are driven low, so the outputs are always deterministic.

Auto-refresh, self-refresh entry and load-command-register share the same strobe pattern. The block tells them apart by the clock-enable edge it produces and by whether it drives bank and address bits. It tracks a power mode (running, self-refresh or power-down) so that clock enable falls on entry and rises with chip-select high on exit. Requests that the current mode does not allow are refused with a one-cycle error pulse.

After reset the block is idle. A strap input selects whether it is the boot device. If it is, the block is enabled at once. If not, it stays disabled until it receives an enable pulse.

Top module: `sdram_cmd_seq`

## Requirements
- R1: During and after reset the pins show the idle pattern: cke=1, cs_n=1, ras_n=cas_n=we_n=0, address and bank 0, req_err=0, mode running. After reset, req_ready equals the boot_sel value held during reset.
- R2: While disabled, req_ready is 0. Any request, legal or not, leaves the pins at the idle pattern of the current mode and raises no error.
- R3: A pulse on en_clr disables the block at the next edge, and a pulse on en_set enables it. If both arrive together, en_clr wins.
- R4: Read (op 2) drives {cke,cs_n,ras_n,cas_n,we_n}=10101, and write (op 3) drives 10100. Both put req_addr on the address lines with bit 10 forced to 0, and req_bank on the bank lines.
- R5: Activate (op 4) drives 10011 with req_addr and req_bank passed through unchanged.
- R6: Precharge one bank (op 6) drives 10010 with all address bits 0 and req_bank. Precharge all (op 7) drives 10010 with only address bit 10 set and bank 0.
- R7: Auto-refresh (op 8) drives 10001 with address and bank 0. Load command register (op 9) drives 10001 with address bits [9:0] and the bank from the request. Mode register set (op 10) drives 10000 with bits [9:0] and the bank from the request. Burst terminate (op 5) drives 10110 with the bank only. In all three of ops 9, 10 and 5, any address bits not named are 0.
- R8: A request is taken only when req_valid and req_ready are both high at a clock edge. Its pins appear for exactly the one cycle after that edge. In that following cycle req_ready is 0 and the pins show idle.
- R9: Self-refresh entry (op 11) drives 00001 and enters self-refresh, where idle cycles have cke=0. Self-refresh exit (op 12) drives 11000 and returns to running.
- R10: Power-down entry (op 13) drives 01000 and enters power-down, where idle cycles have cke=0. Power-down exit (op 14) drives 11000 and returns to running.
- R11: In self-refresh only ops 0, 1 and 12 are accepted, and in power-down only ops 0, 1 and 14. Any other accepted request yields req_err=1 for one cycle and idle pins, and leaves the mode unchanged.
- R12: In running mode, op 12, op 14 and the reserved op 15 are refused with req_err as in R11.
- R13: Deselect (op 0) drives cs_n=1 with the other strobes 0. NOP (op 1) drives cs_n=0 with ras_n=cas_n=we_n=1. For both, cke follows the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_sel | input | 1 | Strap: block is the boot device, sampled during reset |
| en_set | input | 1 | Enable pulse |
| en_clr | input | 1 | Disable pulse, wins over en_set |
| req_valid | input | 1 | Request present |
| req_op | input | 4 | Operation code (see requirements) |
| req_bank | input | BANK_W | Bank for the request |
| req_addr | input | ADDR_W | Row/column/mode value for the request |
| req_ready | output | 1 | A request would be taken at the next edge |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address lines |
| sd_ba | output | BANK_W | Bank lines |
| req_err | output | 1 | One-cycle pulse for a refused request |

## Verification
A wrong power mode shows on the first idle cycle that follows: clock enable sits at the wrong level, and the next request is accepted or refused wrongly. A stuck spacing flag shows as req_ready staying low, or as two command cycles back to back. A bad enable register shows as req_ready disagreeing with the strap or the enable pulses one cycle after the edge. Because every output is registered, each of these faults reaches the pins one edge after its cause, so a bench that models mode, enable and spacing can compare every cycle.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    OP_DSEL = 4'd0,  OP_NOP  = 4'd1,  OP_READ = 4'd2,  OP_WRITE = 4'd3,
    OP_ACT  = 4'd4,  OP_BST  = 4'd5,  OP_PRE  = 4'd6,  OP_PALL  = 4'd7,
    OP_REF  = 4'd8,  OP_LCR  = 4'd9,  OP_MRS  = 4'd10, OP_SRE   = 4'd11,
    OP_SRX  = 4'd12, OP_PDE  = 4'd13, OP_PDX  = 4'd14, OP_RSVD  = 4'd15
  } sd_op_e;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_SELF = 2'd1,
    PM_PDN  = 2'd2
  } pm_e;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ctl_t;

  // Idle pattern for a mode: deselect, strobes low, cke high only when running.
  function automatic ctl_t ctl_idle(pm_e pm);
    ctl_t c;
    c = '{cke: (pm == PM_RUN), cs_n: 1'b1, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    return c;
  endfunction

  // Whether an operation may be issued in the given mode.
  function automatic logic op_legal(sd_op_e op, pm_e pm);
    logic ok;
    unique case (pm)
      PM_SELF: ok = (op == OP_DSEL) || (op == OP_NOP) || (op == OP_SRX);
      PM_PDN:  ok = (op == OP_DSEL) || (op == OP_NOP) || (op == OP_PDX);
      default: ok = (op != OP_SRX) && (op != OP_PDX) && (op != OP_RSVD);
    endcase
    return ok;
  endfunction

  // Mode after an issued operation.
  function automatic pm_e pm_after(sd_op_e op, pm_e pm);
    pm_e n;
    case (op)
      OP_SRE:         n = PM_SELF;
      OP_PDE:         n = PM_PDN;
      OP_SRX, OP_PDX: n = PM_RUN;
      default:        n = pm;
    endcase
    return n;
  endfunction

  // Control pins for an issued operation.
  function automatic ctl_t ctl_of(sd_op_e op, pm_e pm);
    ctl_t c;
    c = ctl_idle(pm);
    case (op)
      OP_NOP:         c = '{cke: (pm == PM_RUN), cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      OP_READ:        c = 5'b10101;
      OP_WRITE:       c = 5'b10100;
      OP_ACT:         c = 5'b10011;
      OP_BST:         c = 5'b10110;
      OP_PRE,
      OP_PALL:        c = 5'b10010;
      OP_REF, OP_LCR: c = 5'b10001;
      OP_MRS:         c = 5'b10000;
      OP_SRE:         c = 5'b00001;
      OP_PDE:         c = 5'b01000;
      OP_SRX, OP_PDX: c = 5'b11000;
      default:        c = ctl_idle(pm);
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_enable.sv
module sdcmd_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_sel,
  input  logic en_set,
  input  logic en_clr,
  output logic en
);
  always_ff @(posedge clk) begin
    if (!rst_n)      en <= boot_sel;
    else if (en_clr) en <= 1'b0;
    else if (en_set) en <= 1'b1;
  end
endmodule

// File: rtl/sdcmd_pwr.sv
module sdcmd_pwr
  import sdcmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   issue,
  input  sd_op_e op,
  output pm_e    pm,
  output logic   legal
);
  assign legal = op_legal(op, pm);

  always_ff @(posedge clk) begin
    if (!rst_n)     pm <= PM_RUN;
    else if (issue) pm <= pm_after(op, pm);
  end
endmodule

// File: rtl/sdcmd_pins.sv
module sdcmd_pins
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  sd_op_e            op,
  input  pm_e               pm,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  output ctl_t              ctl,
  output logic [ADDR_W-1:0] a_o,
  output logic [BANK_W-1:0] ba_o
);
  localparam int AP_BIT = 10;
  localparam int COL_W  = AP_BIT;

  // Address lines for an operation.
  function automatic logic [ADDR_W-1:0] addr_of(sd_op_e o, logic [ADDR_W-1:0] v);
    logic [ADDR_W-1:0] r;
    r = '0;
    case (o)
      OP_READ, OP_WRITE: begin r = v; r[AP_BIT] = 1'b0; end
      OP_ACT:            r = v;
      OP_PALL:           r[AP_BIT] = 1'b1;
      OP_LCR, OP_MRS:    r[COL_W-1:0] = v[COL_W-1:0];
      default:           r = '0;
    endcase
    return r;
  endfunction

  // Bank lines for an operation.
  function automatic logic [BANK_W-1:0] bank_of(sd_op_e o, logic [BANK_W-1:0] b);
    logic [BANK_W-1:0] r;
    case (o)
      OP_READ, OP_WRITE, OP_ACT, OP_PRE,
      OP_BST, OP_LCR, OP_MRS: r = b;
      default:                r = '0;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl  <= ctl_idle(PM_RUN);
      a_o  <= '0;
      ba_o <= '0;
    end else if (issue) begin
      ctl  <= ctl_of(op, pm);
      a_o  <= addr_of(op, addr);
      ba_o <= bank_of(op, bank);
    end else begin
      ctl  <= ctl_idle(pm);
      a_o  <= '0;
      ba_o <= '0;
    end
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_sel,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic              req_err
);
  sd_op_e op;
  pm_e    pm;
  ctl_t   ctl;
  logic   en_q;
  logic   gap_q;
  logic   legal;
  logic   take;
  logic   issue;
  logic   refuse;

  assign op        = sd_op_e'(req_op);
  assign req_ready = en_q && !gap_q;
  assign take      = req_valid && req_ready;
  assign issue     = take && legal;
  assign refuse    = take && !legal;

  sdcmd_enable u_en (
    .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel),
    .en_set(en_set), .en_clr(en_clr), .en(en_q)
  );

  sdcmd_pwr u_pwr (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op),
    .pm(pm), .legal(legal)
  );

  sdcmd_pins #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .pm(pm),
    .bank(req_bank), .addr(req_addr),
    .ctl(ctl), .a_o(sd_addr), .ba_o(sd_ba)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q   <= 1'b0;
      req_err <= 1'b0;
    end else begin
      gap_q   <= issue;
      req_err <= refuse;
    end
  end

  assign sd_cke   = ctl.cke;
  assign sd_cs_n  = ctl.cs_n;
  assign sd_ras_n = ctl.ras_n;
  assign sd_cas_n = ctl.cas_n;
  assign sd_we_n  = ctl.we_n;
endmodule

// File: rtl/sdcmd_chk.sv
module sdcmd_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic              req_ready,
  input logic              req_err,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr
);
  // R8
  spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |=> sd_cs_n);

  // R2
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (sd_cs_n && !req_err));

  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !req_ready);

  // R9
  cke_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_cke) |-> (sd_cs_n || (!sd_ras_n && !sd_cas_n && sd_we_n)));

  // R10
  cke_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_cke) |-> sd_cs_n);

  // R11
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (sd_cs_n && $stable(sd_cke)));

  // R11
  lowpow_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cke && !sd_cs_n) |-> (sd_ras_n && sd_cas_n && sd_we_n) || !sd_ras_n);

  // R7
  mrs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n) |-> (sd_addr[ADDR_W-1:10] == '0));
endmodule

bind sdram_cmd_seq sdcmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .req_ready(req_ready),
  .req_err(req_err), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_addr(sd_addr)
);

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_sel = 1'b0;
  logic        en_set = 1'b0;
  logic        en_clr = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = 4'd0;
  logic [1:0]  req_bank = 2'd0;
  logic [11:0] req_addr = 12'd0;
  logic        req_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, req_err;
  logic [11:0] sd_addr;
  logic [1:0]  sd_ba;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state: mode 0 run, 1 self, 2 power-down
  int  m_mode = 0;
  bit  m_en = 0;
  bit  m_gap = 0;
  logic [18:0] m_pins;
  bit  m_err = 0;

  always #5 clk = ~clk;

  sdram_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel), .en_set(en_set), .en_clr(en_clr),
    .req_valid(req_valid), .req_op(req_op), .req_bank(req_bank), .req_addr(req_addr),
    .req_ready(req_ready), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .req_err(req_err)
  );

  function automatic logic [18:0] idle_pins(int mode);
    return {(mode == 0), 4'b1000, 12'd0, 2'd0};
  endfunction

  function automatic bit allowed(int op, int mode);
    if (mode == 1) return op == 0 || op == 1 || op == 12;
    if (mode == 2) return op == 0 || op == 1 || op == 14;
    return !(op == 12 || op == 14 || op == 15);
  endfunction

  // {cke,cs_n,ras_n,cas_n,we_n, addr[11:0], bank[1:0]}
  function automatic logic [18:0] cmd_pins(int op, int mode, logic [1:0] b, logic [11:0] a);
    logic k;
    k = (mode == 0);
    case (op)
      0:  return {k, 4'b1000, 12'd0, 2'd0};
      1:  return {k, 4'b0111, 12'd0, 2'd0};
      2:  return {5'b10101, a[11], 1'b0, a[9:0], b};
      3:  return {5'b10100, a[11], 1'b0, a[9:0], b};
      4:  return {5'b10011, a, b};
      5:  return {5'b10110, 12'd0, b};
      6:  return {5'b10010, 12'd0, b};
      7:  return {5'b10010, 12'h400, 2'd0};
      8:  return {5'b10001, 12'd0, 2'd0};
      9:  return {5'b10001, 2'b00, a[9:0], b};
      10: return {5'b10000, 2'b00, a[9:0], b};
      11: return {5'b00001, 12'd0, 2'd0};
      13: return {5'b01000, 12'd0, 2'd0};
      default: return {5'b11000, 12'd0, 2'd0};
    endcase
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1:   return "R13";
      2, 3:   return "R4";
      4:      return "R5";
      6, 7:   return "R6";
      5, 8, 9, 10: return "R7";
      11, 12: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model the edge, compare at next negedge.
  task automatic step(bit v, int op, logic [1:0] b, logic [11:0] a, bit s, bit c);
    bit take, ok;
    string tag;
    check("R8", "ready", {31'd0, req_ready}, {31'd0, m_en && !m_gap});
    req_valid = v; req_op = op[3:0]; req_bank = b; req_addr = a;
    en_set = s; en_clr = c;
    @(posedge clk);
    take = v && m_en && !m_gap;
    ok = allowed(op, m_mode);
    if (!m_en) tag = "R2";
    else if (!take) tag = "R8";
    else if (!ok) tag = (m_mode == 0) ? "R12" : "R11";
    else tag = tag_of(op);
    if (take && ok) begin
      m_pins = cmd_pins(op, m_mode, b, a);
      if (op == 11) m_mode = 1;
      if (op == 13) m_mode = 2;
      if (op == 12 || op == 14) m_mode = 0;
    end else m_pins = idle_pins(m_mode);
    m_err = take && !ok;
    m_gap = take && ok;
    if (c) m_en = 0; else if (s) m_en = 1;
    @(negedge clk);
    req_valid = 0; en_set = 0; en_clr = 0;
    check(tag, "pins", {13'd0, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba},
          {13'd0, m_pins});
    check(tag, "err", {31'd0, req_err}, {31'd0, m_err});
    if (s || c) begin
      checks++;
      if (req_ready !== (m_en && !m_gap)) begin
        errors++;
        $display("FAIL R3 ready after enable change: actual=%0b expected=%0b",
                 req_ready, m_en && !m_gap);
      end
    end
  endtask

  task automatic do_reset(bit boot);
    @(negedge clk);
    rst_n = 0; boot_sel = boot; req_valid = 0; en_set = 0; en_clr = 0;
    repeat (3) @(negedge clk);
    check("R1", "pins in reset", {13'd0, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba},
          {13'd0, idle_pins(0)});
    rst_n = 1;
    @(negedge clk);
    m_mode = 0; m_en = boot; m_gap = 0; m_err = 0;
    check("R1", "ready after reset", {31'd0, req_ready}, {31'd0, boot});
    check("R1", "pins after reset", {13'd0, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba},
          {13'd0, idle_pins(0)});
    check("R1", "err after reset", {31'd0, req_err}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5d1c;
    void'($urandom(seed));
    do_reset(0);
    // R2: disabled block ignores legal and illegal requests
    step(1, 2, 2'd1, 12'h123, 0, 0);
    step(1, 15, 2'd0, 12'h0, 0, 0);
    step(1, 11, 2'd0, 12'h0, 0, 0);
    // R3: enable, then clear wins over set
    step(0, 0, 0, 0, 1, 0);
    step(1, 4, 2'd3, 12'hABC, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    step(1, 3, 2'd2, 12'hFFF, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    // directed corner cases
    step(1, 3, 2'd2, 12'hFFF, 0, 0);  // R4 bit 10 forced low
    step(1, 2, 2'd1, 12'h400, 0, 0);  // R8 refused by spacing
    step(1, 7, 2'd3, 12'hFFF, 0, 0);  // R6
    step(0, 0, 0, 0, 0, 0);
    step(1, 10, 2'd1, 12'hFFF, 0, 0); // R7
    step(0, 0, 0, 0, 0, 0);
    step(1, 12, 2'd0, 12'h0, 0, 0);   // R12
    step(1, 15, 2'd0, 12'h0, 0, 0);   // R12
    step(1, 11, 2'd0, 12'h0, 0, 0);   // R9 entry
    step(0, 0, 0, 0, 0, 0);
    step(1, 2, 2'd0, 12'h5, 0, 0);    // R11
    step(1, 14, 2'd0, 12'h0, 0, 0);   // R11 wrong exit
    step(1, 1, 2'd0, 12'h0, 0, 0);    // R13 NOP in low power
    step(0, 0, 0, 0, 0, 0);
    step(1, 12, 2'd0, 12'h0, 0, 0);   // R9 exit
    step(0, 0, 0, 0, 0, 0);
    step(1, 13, 2'd0, 12'h0, 0, 0);   // R10 entry
    step(0, 0, 0, 0, 0, 0);
    step(1, 8, 2'd0, 12'h0, 0, 0);    // R11
    step(1, 14, 2'd0, 12'h0, 0, 0);   // R10 exit
    step(0, 0, 0, 0, 0, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = (m_mode != 0 && $urandom_range(0, 3) == 0) ? ((m_mode == 1) ? 12 : 14)
                                                       : int'($urandom_range(0, 15));
      step($urandom_range(0, 3) != 0, op, 2'($urandom), 12'($urandom),
           $urandom_range(0, 49) == 0, $urandom_range(0, 99) == 0);
      if (!m_en) step(0, 0, 0, 0, 1, 0);
    end
    do_reset(1);
    step(1, 9, 2'd2, 12'hFFF, 0, 0);  // R7 load command register
    step(0, 0, 0, 0, 0, 0);
    step(1, 5, 2'd3, 12'hFFF, 0, 0);  // R7 burst terminate
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule